// File: doc/BRIEF.md
# Descriptor Ring Poll Timer Pair

This block issues periodic poll requests for two descriptor rings, one for transmit and one for receive. Each ring has its own timer channel, made of a free-running time counter and an interval register. The interval holds the two's complement of the wanted period in clock cycles. A seventeenth bit of one sits above the 16-bit field, so every bit of the field adds to the magnitude. The low four bits are dropped, so periods are multiples of 16 clocks. When a channel's counter carries out, the channel raises a one-cycle poll request and reloads from its interval.

Software reaches the four registers through a simple 32-bit read/write port. Access is open only while the stop input or the suspend input is high. An init input puts both intervals back to their default, which is the longest period. The hard and soft resets clear the request outputs, but the counters and intervals keep their contents.

Top module: `poll_timer_pair`

## Requirements
- R1: The two channels run independently. Register select `reg_addr` 0 is the transmit counter, 1 the transmit interval, 2 the receive counter and 3 the receive interval.
- R2: Let I be an interval value with its low nibble cleared. A channel running from a reload pulses every 65536 - I clocks, so an interval of 0000h gives 65536 clocks.
- R3: Bits [3:0] of an interval write are ignored. They read back as zero and have no effect on the period.
- R4: A poll request is a single-cycle pulse. It is high in the cycle after the edge on which the counter carries out of its 17th bit, and that same edge reloads the counter from the interval.
- R5: A write takes effect only while `stop` or `suspend` is high, and is discarded otherwise. `reg_rdata` is zero unless `reg_rd` is high and `stop` or `suspend` is high.
- R6: Bits [31:16] of `reg_rdata` are always zero, and bits [31:16] of write data have no effect.
- R7: While `stop` is high the counters hold their value and no poll request is raised. `suspend` alone does not pause counting.
- R8: `init` loads 0000h into both intervals and restarts both counters at 0000h, which gives a full 65536-clock period. A register write in the same cycle is ignored.
- R9: `rst_hard` or `rst_soft` clears both poll outputs. While either is high, the counters, intervals and register writes are frozen, so their contents survive the reset.
- R10: Writing value V to a counter register loads it at once. A running channel then pulses after 65536 - V clocks, and reading the counter returns its current 16-bit count.
- R11: An interval write leaves the current count alone. The new interval is used from the next reload on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_hard | input | 1 | Hard reset, synchronous, active high |
| rst_soft | input | 1 | Soft reset, synchronous, active high |
| stop | input | 1 | Stop: freezes counting and opens register access |
| suspend | input | 1 | Suspend: opens register access, counting continues |
| init | input | 1 | Load default intervals and restart counters |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| poll_tx | output | 1 | Transmit ring poll request pulse |
| poll_rx | output | 1 | Receive ring poll request pulse |

## Verification
The two channels are loaded with different counter starts and different intervals, so that a swapped or shared channel shows up as a pulse in the wrong cycle. One interval write carries a non-zero low nibble and a later one lands mid-count, which separates the dropped nibble and the deferred reload from an immediate update. The stop, suspend, reset and out-of-window write phases each leave a counter or interval whose read-back or pulse timing would differ if that gating failed. A final run at the default interval confirms the full 65536-clock period after init, with a competing write in the init cycle.

// File: rtl/poll_timer_pkg.sv
package poll_timer_pkg;

    localparam int FIELD_W = 16;
    localparam int NIB_W   = 4;
    localparam int BUS_W   = 32;
    localparam int ADDR_W  = 2;
    localparam int NUM_CH  = 2;
    localparam int CNT_W   = FIELD_W + 1;
    localparam int HI_W    = FIELD_W - NIB_W;

    typedef enum logic [ADDR_W-1:0] {
        SEL_TX_CNT = 2'd0,
        SEL_TX_IVL = 2'd1,
        SEL_RX_CNT = 2'd2,
        SEL_RX_IVL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic               cnt_we;
        logic               ivl_we;
        logic [FIELD_W-1:0] data;
    } chan_wr_t;

    typedef struct packed {
        logic [FIELD_W-1:0] cnt;
        logic [FIELD_W-1:0] ivl;
    } chan_view_t;

    function automatic logic [CNT_W-1:0] reload_of(input logic [HI_W-1:0] ivl_hi);
        return {1'b1, ivl_hi, {NIB_W{1'b0}}};
    endfunction

    function automatic logic [ADDR_W-1:0] cnt_sel(input int ch);
        return (ch == 0) ? SEL_TX_CNT : SEL_RX_CNT;
    endfunction

    function automatic logic [ADDR_W-1:0] ivl_sel(input int ch);
        return (ch == 0) ? SEL_TX_IVL : SEL_RX_IVL;
    endfunction

endpackage

// File: rtl/poll_channel.sv
module poll_channel
    import poll_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stop,
    input  logic       init,
    input  chan_wr_t   wr,
    output chan_view_t view,
    output logic       poll
);

    logic [CNT_W-1:0] cnt_q;
    logic [HI_W-1:0]  ivl_q;
    logic             poll_q;
    logic             carry;

    assign carry = &cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            poll_q <= 1'b0;
        end else begin
            poll_q <= 1'b0;
            if (init) begin
                ivl_q <= '0;
                cnt_q <= reload_of('0);
            end else begin
                if (wr.ivl_we)
                    ivl_q <= wr.data[FIELD_W-1:NIB_W];
                if (wr.cnt_we) begin
                    cnt_q <= {1'b1, wr.data};
                end else if (!stop) begin
                    if (carry) begin
                        cnt_q  <= reload_of(ivl_q);
                        poll_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end
        end
    end

    assign view.cnt = cnt_q[FIELD_W-1:0];
    assign view.ivl = {ivl_q, {NIB_W{1'b0}}};
    assign poll     = poll_q;

    // R4: a request never lasts two cycles
    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        poll_q |=> !poll_q);

    // R4, R11: the pulse cycle shows the counter reloaded from the prior interval
    assert_reload_value_R4: assert property (@(posedge clk) disable iff (rst)
        poll_q |-> (cnt_q == reload_of($past(ivl_q))));

    // R7: stop freezes the count
    assert_stop_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (stop && !init && !wr.cnt_we) |=> (cnt_q == $past(cnt_q)));

    // R7: no request follows a stopped cycle
    assert_stop_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        stop |=> !poll_q);

    // R8: init restores the default interval and restarts the count
    assert_init_default_R8: assert property (@(posedge clk) disable iff (rst)
        init |=> (ivl_q == '0) && (cnt_q == reload_of('0)));

endmodule

// File: rtl/poll_regif.sv
module poll_regif
    import poll_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stop,
    input  logic              suspend,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    input  chan_view_t        views [NUM_CH],
    output chan_wr_t          wrs   [NUM_CH],
    output logic [BUS_W-1:0]  reg_rdata
);

    logic open_win;
    assign open_win = stop | suspend;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_wr
        assign wrs[ch].cnt_we = reg_wr && open_win && (reg_addr == cnt_sel(ch));
        assign wrs[ch].ivl_we = reg_wr && open_win && (reg_addr == ivl_sel(ch));
        assign wrs[ch].data   = reg_wdata[FIELD_W-1:0];
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd && open_win) begin
            case (reg_addr)
                SEL_TX_CNT: reg_rdata[FIELD_W-1:0] = views[0].cnt;
                SEL_TX_IVL: reg_rdata[FIELD_W-1:0] = views[0].ivl;
                SEL_RX_CNT: reg_rdata[FIELD_W-1:0] = views[1].cnt;
                default:    reg_rdata[FIELD_W-1:0] = views[1].ivl;
            endcase
        end
    end

    // R5: data appears only on a permitted read
    assert_read_gated_R5: assert property (@(posedge clk) disable iff (rst)
        (|reg_rdata) |-> (reg_rd && open_win));

    // R5: no write strobe reaches a channel outside the window
    assert_write_gated_R5: assert property (@(posedge clk) disable iff (rst)
        !open_win |-> !(wrs[0].cnt_we || wrs[0].ivl_we || wrs[1].cnt_we || wrs[1].ivl_we));

    // R6: reserved upper half reads zero
    assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[BUS_W-1:FIELD_W] == '0);

endmodule

// File: rtl/poll_timer_pair.sv
module poll_timer_pair
    import poll_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_hard,
    input  logic              rst_soft,
    input  logic              stop,
    input  logic              suspend,
    input  logic              init,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    output logic              poll_tx,
    output logic              poll_rx
);

    logic             rst;
    chan_wr_t         wrs   [NUM_CH];
    chan_view_t       views [NUM_CH];
    logic [NUM_CH-1:0] polls;

    assign rst = rst_hard | rst_soft;

    poll_regif u_regif (
        .clk       (clk),
        .rst       (rst),
        .stop      (stop),
        .suspend   (suspend),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .views     (views),
        .wrs       (wrs),
        .reg_rdata (reg_rdata)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        poll_channel u_chan (
            .clk  (clk),
            .rst  (rst),
            .stop (stop),
            .init (init),
            .wr   (wrs[ch]),
            .view (views[ch]),
            .poll (polls[ch])
        );
    end

    assign poll_tx = polls[0];
    assign poll_rx = polls[1];

    // R9: reset clears both requests
    assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> !(poll_tx || poll_rx));

endmodule

// File: tb/test_poll_timer_pair.sv
module test_poll_timer_pair;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_hard = 1'b0, rst_soft = 1'b0;
    logic        stop = 1'b0, suspend = 1'b0, init = 1'b0;
    logic        reg_rd = 1'b0, reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        poll_tx, poll_rx;

    int checks = 0;
    int errors = 0;
    bit compare_on = 0;
    bit done = 0;

    // behavioural reference: cycles remaining to the next carry, per channel
    int rem [2];
    int ivl [2];
    bit exp_poll [2];
    int seen_tx = 0, seen_rx = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    poll_timer_pair i_poll_timer_pair (
        .clk(clk), .rst_hard(rst_hard), .rst_soft(rst_soft), .stop(stop),
        .suspend(suspend), .init(init), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .poll_tx(poll_tx), .poll_rx(poll_rx)
    );

    always @(posedge clk) begin
        for (int ch = 0; ch < 2; ch++) begin
            if (rst_hard || rst_soft) begin
                exp_poll[ch] = 0;                       // R9
            end else begin
                exp_poll[ch] = 0;
                if (init) begin
                    ivl[ch] = 0;                         // R8
                    rem[ch] = 65536;
                end else begin
                    if (reg_wr && (stop || suspend) && reg_addr == 2'(ch*2))
                        rem[ch] = 65536 - int'(reg_wdata[15:0]);   // R10
                    else if (!stop) begin               // R7
                        if (rem[ch] == 1) begin
                            exp_poll[ch] = 1;            // R4
                            rem[ch] = 65536 - ivl[ch];   // R2, R11
                        end else rem[ch] = rem[ch] - 1;
                    end
                    if (reg_wr && (stop || suspend) && reg_addr == 2'(ch*2+1))
                        ivl[ch] = int'(reg_wdata[15:0]) & 32'hFFF0;  // R3
                end
            end
        end
    end

    // per-cycle comparison of the request outputs (R1, R2, R4)
    always @(negedge clk) begin
        if (compare_on) begin
            checks++;
            if (poll_tx !== exp_poll[0]) begin
                errors++;
                $display("FAIL R4 poll_tx at %0t: got %0b expected %0b", $time, poll_tx, exp_poll[0]);
            end
            checks++;
            if (poll_rx !== exp_poll[1]) begin
                errors++;
                $display("FAIL R1 poll_rx at %0t: got %0b expected %0b", $time, poll_rx, exp_poll[1]);
            end
            if (poll_tx) seen_tx++;
            if (poll_rx) seen_rx++;
        end
    end

    function automatic int model_val(input int a);
        case (a)
            0: return (65536 - rem[0]) & 32'hFFFF;
            1: return ivl[0];
            2: return (65536 - rem[1]) & 32'hFFFF;
            default: return ivl[1];
        endcase
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic read_check(input logic [1:0] a, input logic [31:0] expv, input string tag);
        reg_rd = 1'b1; reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== expv) begin
            errors++;
            $display("FAIL %s read addr %0d: got %h expected %h", tag, a, reg_rdata, expv);
        end
        reg_rd = 1'b0;
    endtask

    task automatic check_val(input int got, input int expv, input string tag);
        checks++;
        if (got != expv) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, expv);
        end
    endtask

    initial begin
        rem = '{65536, 65536}; ivl = '{0, 0}; exp_poll = '{0, 0};
        // R9: reset state
        rst_hard = 1'b1;
        step(3);
        compare_on = 1;
        rst_hard = 1'b0;
        read_check(2'd0, 32'h0, "R5 closed window");

        // R8: init with stop held
        stop = 1'b1; init = 1'b1;
        step(1);
        init = 1'b0;
        read_check(2'd0, 32'h0, "R8 tx counter");
        read_check(2'd3, 32'h0, "R8 rx interval");

        // R3, R6, R10: program both channels while stopped
        do_write(2'd1, 32'h1234_FFC5);
        read_check(2'd1, 32'h0000_FFC0, "R3 tx interval nibble");
        do_write(2'd3, 32'h0000_FF80);
        do_write(2'd0, 32'hABCD_FFF0);
        read_check(2'd0, 32'h0000_FFF0, "R6 tx counter");
        do_write(2'd2, 32'h0000_FFE0);
        read_check(2'd2, 32'h0000_FFE0, "R10 rx counter");

        // R2, R4: run both channels
        stop = 1'b0;
        step(600);
        check_val(seen_tx, 1 + (600 - 16) / 64, "R2 tx pulses in window");
        check_val(seen_rx, 1 + (600 - 32) / 128, "R2 rx pulses in window");

        // R5: write outside the window is discarded
        do_write(2'd1, 32'h0000_FFF0);
        read_check(2'd1, 32'h0, "R5 read closed");
        suspend = 1'b1;
        read_check(2'd1, 32'h0000_FFC0, "R5 discarded write");

        // R11, R7: interval change mid-count while suspended and counting
        step(37);
        do_write(2'd3, 32'h0000_FFF0);
        read_check(2'd3, 32'h0000_FFF0, "R11 rx interval");
        step(300);

        // R7: stop freezes
        stop = 1'b1; suspend = 1'b0;
        step(2);
        read_check(2'd0, 32'(model_val(0)), "R7 tx counter stopped");
        begin
            logic [31:0] snap;
            reg_rd = 1'b1; reg_addr = 2'd2; #1; snap = reg_rdata; reg_rd = 1'b0;
            step(50);
            read_check(2'd2, snap, "R7 rx counter held");
        end

        // R9: soft reset while running keeps state
        stop = 1'b0;
        step(23);
        rst_soft = 1'b1;
        step(4);
        rst_soft = 1'b0;
        suspend = 1'b1;
        read_check(2'd1, 32'h0000_FFC0, "R9 tx interval survives");
        read_check(2'd2, 32'(model_val(2)), "R9 rx counter survives");
        step(200);

        // R8: init beats a simultaneous write, then full default period
        suspend = 1'b0; stop = 1'b1;
        init = 1'b1; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h0000_FFF0;
        step(1);
        init = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        read_check(2'd1, 32'h0, "R8 init beats write");
        read_check(2'd2, 32'h0, "R8 rx counter restart");
        seen_tx = 0; seen_rx = 0;
        stop = 1'b0;
        step(65545);
        check_val(seen_tx, 1, "R2 default tx period");
        check_val(seen_rx, 1, "R2 default rx period");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule